// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit resolves the conditional-branch class of a 64-bit integer core. Each cycle it may accept one 32-bit instruction word, the address that word was fetched from, and the two 64-bit source operands. It recognises the branch opcode and rebuilds the 13-bit signed displacement from four scattered instruction fields. It then evaluates the comparison that the three-bit condition field selects, and forms two addresses: the jump destination, measured from the branch's own address, and the sequential successor.

The result is registered. One cycle after a qualified input, the output holds a qualifier, a taken flag, a reserved-encoding flag, the destination and the fall-through address. With no qualified input the qualifier drops, and the other registered fields keep their last values. Reading registers, flushing a pipeline and trapping on a misaligned destination are left to the surrounding core.

Top module: `br_resolve`

## Requirements
- R1: After a synchronous active-high reset, res_vld, res_taken and res_bad are 0; res_tgt and res_seq are 0.
- R2: res_vld equals the previous cycle's in_vld. When in_vld is 0, res_taken, res_bad, res_tgt and res_seq keep their values.
- R3: A word is a branch when bits 6:0 equal 7'b1100011. For any other value, res_taken and res_bad are 0.
- R4: The displacement takes its bit 12 from word bit 31, bits 10:5 from word bits 30:25, bits 4:1 from word bits 11:8 and bit 11 from word bit 7. Its bit 0 is 0. It is sign-extended from bit 12 to 64 bits.
- R5: res_tgt equals in_pc plus the sign-extended displacement, modulo 2^64. This holds for every opcode.
- R6: res_seq equals in_pc + 4, modulo 2^64.
- R7: Condition field bits 14:12 equal to 000 take the branch when the operands are equal. The value 001 takes it when they differ.
- R8: The value 100 takes the branch when the first operand is less than the second, both read as two's-complement numbers. The value 101 takes it when the first is greater than or equal to the second.
- R9: The values 110 and 111 make the same two comparisons as R8, with both operands read as unsigned numbers.
- R10: For a branch word whose condition field is 010 or 011, res_bad is 1 and res_taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies this cycle's inputs |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| in_a | input | 64 | First source operand |
| in_b | input | 64 | Second source operand |
| res_vld | output | 1 | Registered result qualifier |
| res_taken | output | 1 | Branch taken |
| res_bad | output | 1 | Reserved condition encoding |
| res_tgt | output | 64 | Jump destination |
| res_seq | output | 64 | Fall-through address |

## Verification
Every result lands exactly one rising edge after the inputs that produced it, because the only registers are the output registers. The bench drives each vector just after a falling edge, waits through one rising edge, and samples at the next falling edge. At that point it compares all five outputs with values its own functions computed from the same vector. To check the hold behaviour, it drives idle cycles with changed inputs and confirms that the fields still show the previous result.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
  localparam int XLEN  = 64;
  localparam int ILEN  = 32;
  localparam int OFFW  = 13;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [2:0] {
    CC_EQ  = 3'b000,
    CC_NE  = 3'b001,
    CC_R2  = 3'b010,
    CC_R3  = 3'b011,
    CC_LT  = 3'b100,
    CC_GE  = 3'b101,
    CC_LTU = 3'b110,
    CC_GEU = 3'b111
  } cond_e;

  typedef struct packed {
    logic          is_br;
    cond_e         cond;
    logic [OFFW-1:0] disp;
  } dec_t;
endpackage

// File: rtl/br_field_dec.sv
module br_field_dec
  import br_resolve_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int DW = OFFW
) (
  input  logic [IW-1:0] insn,
  output dec_t          dec
);
  always_comb begin
    dec.is_br = (insn[6:0] == OPC_BRANCH);
    dec.cond  = cond_e'(insn[14:12]);
    dec.disp  = {insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
  end

  initial begin
    // R4
    disp_width_chk: assert (DW == 13);
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_resolve_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         is_br,
  input  cond_e        cond,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         take,
  output logic         bad
);
  logic eq, lts, ltu;
  always_comb begin
    eq  = (a == b);
    lts = ($signed(a) < $signed(b));
    ltu = (a < b);
    take = 1'b0;
    bad  = 1'b0;
    if (is_br) begin
      unique case (cond)
        CC_EQ:  take = eq;
        CC_NE:  take = !eq;
        CC_LT:  take = lts;
        CC_GE:  take = !lts;
        CC_LTU: take = ltu;
        CC_GEU: take = !ltu;
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/br_addr_gen.sv
module br_addr_gen
  import br_resolve_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int DW = OFFW,
  parameter int STEP = 4
) (
  input  logic [W-1:0]  pc,
  input  logic [DW-1:0] disp,
  output logic [W-1:0]  tgt,
  output logic [W-1:0]  seq
);
  logic [W-1:0] disp_x;
  always_comb begin
    disp_x = {{(W-DW){disp[DW-1]}}, disp};
    tgt = pc + disp_x;
    seq = pc + W'(STEP);
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_resolve_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = ILEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [IW-1:0] in_insn,
  input  logic [W-1:0]  in_pc,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          res_vld,
  output logic          res_taken,
  output logic          res_bad,
  output logic [W-1:0]  res_tgt,
  output logic [W-1:0]  res_seq
);
  dec_t         dec;
  logic         take_c, bad_c;
  logic [W-1:0] tgt_c, seq_c;

  br_field_dec #(.IW(IW), .DW(OFFW)) u_dec (.insn(in_insn), .dec(dec));

  br_cond_eval #(.W(W)) u_eval (
    .is_br(dec.is_br), .cond(dec.cond), .a(in_a), .b(in_b),
    .take(take_c), .bad(bad_c));

  br_addr_gen #(.W(W), .DW(OFFW), .STEP(4)) u_addr (
    .pc(in_pc), .disp(dec.disp), .tgt(tgt_c), .seq(seq_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_taken <= 1'b0;
      res_bad   <= 1'b0;
      res_tgt   <= '0;
      res_seq   <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_taken <= take_c;
        res_bad   <= bad_c;
        res_tgt   <= tgt_c;
        res_seq   <= seq_c;
      end
    end
  end

  // R10
  bad_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_bad && res_taken));
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res_tgt) && $stable(res_taken) && $stable(res_seq));
  // R3
  nonbr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_insn[6:0] != OPC_BRANCH) |=> (!res_taken && !res_bad));
  // R10
  rsv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_insn[6:0] == OPC_BRANCH && in_insn[14:13] == 2'b01) |=> res_bad);
endmodule

// File: tb/br_resolve_test.sv
`timescale 1ns/1ps
module br_resolve_test;
  logic clk = 0, rst = 1, in_vld = 0;
  logic [31:0] in_insn = 0;
  logic [63:0] in_pc = 0, in_a = 0, in_b = 0;
  logic res_vld, res_taken, res_bad;
  logic [63:0] res_tgt, res_seq;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  br_resolve uut (.clk, .rst, .in_vld, .in_insn, .in_pc, .in_a, .in_b,
    .res_vld, .res_taken, .res_bad, .res_tgt, .res_seq);

  function automatic logic [63:0] exp_off(logic [31:0] w);
    logic [12:0] o;
    o = 13'd0;
    o[12] = w[31]; o[11] = w[7]; o[10:5] = w[30:25]; o[4:1] = w[11:8];
    return {{51{o[12]}}, o};
  endfunction

  function automatic logic exp_bad(logic [31:0] w);
    return (w[6:0] == 7'h63) && (w[14:12] == 3'd2 || w[14:12] == 3'd3);
  endfunction

  function automatic logic exp_take(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    if (w[6:0] != 7'h63) return 1'b0;
    case (w[14:12])
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mkbr(logic [12:0] o, logic [2:0] f);
    return {o[12], o[10:5], 5'd3, 5'd2, f, o[4:1], o[11], 7'h63};
  endfunction

  task automatic apply(logic [31:0] w, logic [63:0] pc, logic [63:0] a, logic [63:0] b,
                       string tag);
    logic [63:0] et, es;
    logic ek, eb;
    in_vld = 1; in_insn = w; in_pc = pc; in_a = a; in_b = b;
    @(negedge clk);
    in_vld = 0;
    et = pc + exp_off(w); es = pc + 64'd4;
    ek = exp_take(w, a, b); eb = exp_bad(w);
    chk({tag, " R2 vld"}, {63'd0, res_vld}, 64'd1);
    chk({tag, " R7/R8/R9 taken"}, {63'd0, res_taken}, {63'd0, ek});
    chk({tag, " R10 bad"}, {63'd0, res_bad}, {63'd0, eb});
    chk({tag, " R4/R5 tgt"}, res_tgt, et);
    chk({tag, " R6 seq"}, res_seq, es);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1
    chk("R1 vld", {63'd0, res_vld}, 0);
    chk("R1 taken", {63'd0, res_taken}, 0);
    chk("R1 bad", {63'd0, res_bad}, 0);
    chk("R1 tgt", res_tgt, 0);
    chk("R1 seq", res_seq, 0);
    // R7 directed
    apply(mkbr(13'd16, 3'd0), 64'h1000, 64'd5, 64'd5, "R7 eq");
    apply(mkbr(13'd16, 3'd1), 64'h1000, 64'd5, 64'd5, "R7 ne");
    // R8 signed: -1 < 1
    apply(mkbr(13'h1FF0, 3'd4), 64'h2000, '1, 64'd1, "R8 lt");
    apply(mkbr(13'h1FF0, 3'd5), 64'h2000, '1, 64'd1, "R8 ge");
    // R9 unsigned: all-ones > 1
    apply(mkbr(13'h1000, 3'd6), 64'h2000, '1, 64'd1, "R9 ltu");
    apply(mkbr(13'h0FFE, 3'd7), 64'h2000, '1, 64'd1, "R9 geu");
    // R5 wrap-around both ways
    apply(mkbr(13'h1000, 3'd0), 64'h0, 0, 0, "R5 wrap lo");
    apply(mkbr(13'h0FFE, 3'd0), '1, 0, 0, "R5 wrap hi");
    // R10 reserved
    apply(mkbr(13'd8, 3'd2), 64'h40, 1, 1, "R10 r2");
    apply(mkbr(13'd8, 3'd3), 64'h40, 1, 1, "R10 r3");
    // R3 non-branch with branch-like funct3
    apply(32'h0000_0013, 64'h80, 7, 7, "R3 addi");
    apply({25'h1ABCDE, 7'h62}, 64'h80, 7, 7, "R3 near opc");
    // R2 hold: idle with changed inputs
    apply(mkbr(13'd20, 3'd0), 64'h300, 3, 3, "R2 pre");
    in_vld = 0; in_insn = mkbr(13'd100, 3'd1); in_pc = 64'h999; in_a = 1; in_b = 2;
    @(negedge clk);
    chk("R2 idle vld", {63'd0, res_vld}, 0);
    chk("R2 hold taken", {63'd0, res_taken}, 1);
    chk("R2 hold tgt", res_tgt, 64'h314);
    chk("R2 hold seq", res_seq, 64'h304);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] a, b, pc;
      w = $urandom;
      if (i % 4 != 0) w[6:0] = 7'h63;
      pc = {$urandom, $urandom};
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? a : {$urandom, $urandom};
      if (i % 5 == 0) b = {~a[63], a[62:0]};
      apply(w, pc, a, b, "rand");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule